// File: doc/BRIEF.md
# Programmable Sync Edge Pulse Generator

This block turns an external sample-synchronisation input into the internal timing pulse that a downstream timing controller consumes. It has two modes. In bypass mode the external signal reaches the output unchanged and without a clock. In detect mode the input is first brought into the master clock domain. An edge of the chosen polarity is then found, and a pulse one master clock wide is issued after a programmable wait of zero to seven clocks.

All configuration arrives on plain level pins: a detect-enable bit, an edge-polarity bit and a three-bit delay. Both the bypass and detect paths feed the same output pin. No data stream passes through the block, so it has no valid/ready handshake and applies no back-pressure.

Top module: `sync_pulse_gen`

## Requirements
- R1: With `det_en` = 0 and reset released, `sync_out` equals `sync_in` in the same cycle. `edge_pol` and `dly_sel` have no effect on it.
- R2: In detect mode `sync_in` is sampled by two master-clock flops before edge detection. A level held through only one rising clock edge is still captured and detected.
- R3: Suppose the transition of `sync_in` is first sampled at rising edge k with `dly_sel` = D, and `det_en` is 1 from edge k+2 onward. Then `sync_out` is 1 for exactly the cycle that starts at edge k+2+D.
- R4: With `edge_pol` = 0 only 1-to-0 transitions of the synchronised input start a pulse. Rising transitions start nothing.
- R5: With `edge_pol` = 1 only 0-to-1 transitions of the synchronised input start a pulse. Falling transitions start nothing.
- R6: With constant settings, each pulse in detect mode is exactly one cycle high, however long `sync_in` stays at its new level.
- R7: If a new qualifying edge arrives while an earlier pulse is still waiting, the earlier pulse is still issued on time. The new edge gets its own full delay, counted from its own detection.
- R8: While `rst_n` is 0, `sync_out` is 0 in both modes. All synchroniser, edge and pending state clears to 0.
- R9: A rising clock edge sampled with `det_en` = 0 discards every pending pulse, and edges seen while disabled are not queued. After re-enabling, only new edges produce pulses.
- R10: `dly_sel` = 0 adds no delay. The pulse starts at edge k+2, which is the edge right after the one at which the synchronised edge is first visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_m | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_in | input | 1 | Raw external synchronisation input |
| det_en | input | 1 | 0 = bypass, 1 = edge detect with delayed pulse |
| edge_pol | input | 1 | 0 = falling edge, 1 = rising edge |
| dly_sel | input | 3 | Pulse delay in master clock periods (0 to 7) |
| sync_out | output | 1 | Internal synchronisation signal |

## Verification
The hardest situation to reach is a second qualifying edge arriving while an earlier pulse is still in flight, ideally combined with a change of the delay setting or a mode switch. The stimulus reaches it by running a seven-clock delay against an input that toggles every two clocks, so that several pulses are pending at once. It then drops the enable bit in the middle of such a burst and restores it. A final randomised stretch changes the delay, polarity and enable between edges, and a behavioural model keeps a list of scheduled fire times that is compared against the output every cycle.

// File: rtl/sync_pulse_pkg.sv
package sync_pulse_pkg;
  localparam int unsigned DLY_W       = 3;
  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned TAPS        = 1 << DLY_W;

  typedef enum logic {
    POL_FALL = 1'b0,
    POL_RISE = 1'b1
  } edge_pol_e;
endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] stage_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= 1'b0;
          else        stage_q[g] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= 1'b0;
          else        stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/edge_qual.sv
module edge_qual
  import sync_pulse_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic enable,
  input  logic pol,
  output logic hit
);
  logic      lvl_d;
  logic      went_up, went_down;
  edge_pol_e pol_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_d <= 1'b0;
    else        lvl_d <= lvl;
  end

  always_comb begin
    pol_sel   = edge_pol_e'(pol);
    went_up   = lvl & ~lvl_d;
    went_down = ~lvl & lvl_d;
    unique case (pol_sel)
      POL_RISE: hit = enable & went_up;
      POL_FALL: hit = enable & went_down;
      default:  hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/delay_line.sv
module delay_line
  import sync_pulse_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             fire,
  input  logic [DLY_W-1:0] dly,
  output logic             pulse
);
  logic [TAPS-1:0] line_q;

  genvar t;
  generate
    for (t = 0; t < TAPS; t++) begin : g_tap
      logic from_above;
      logic load_here;
      if (t == TAPS - 1) begin : g_top
        assign from_above = 1'b0;
      end else begin : g_mid
        assign from_above = line_q[t+1];
      end
      assign load_here = fire && (dly == DLY_W'(t));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       line_q[t] <= 1'b0;
        else if (!enable) line_q[t] <= 1'b0;
        else              line_q[t] <= from_above | load_here;
      end
    end
  endgenerate

  assign pulse = line_q[0];

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (line_q == '0)) else $error("pending pulse survived disable"); // R9
endmodule

// File: rtl/sync_pulse_gen.sv
module sync_pulse_gen
  import sync_pulse_pkg::*;
(
  input  logic             clk_m,
  input  logic             rst_n,
  input  logic             sync_in,
  input  logic             det_en,
  input  logic             edge_pol,
  input  logic [DLY_W-1:0] dly_sel,
  output logic             sync_out
);
  logic lvl_sync;
  logic edge_hit;
  logic delayed_pulse;

  sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk_m),
    .rst_n (rst_n),
    .d_in  (sync_in),
    .d_out (lvl_sync)
  );

  edge_qual u_edge (
    .clk    (clk_m),
    .rst_n  (rst_n),
    .lvl    (lvl_sync),
    .enable (det_en),
    .pol    (edge_pol),
    .hit    (edge_hit)
  );

  delay_line u_dly (
    .clk    (clk_m),
    .rst_n  (rst_n),
    .enable (det_en),
    .fire   (edge_hit),
    .dly    (dly_sel),
    .pulse  (delayed_pulse)
  );

  always_comb begin
    if (!rst_n)      sync_out = 1'b0;
    else if (det_en) sync_out = delayed_pulse;
    else             sync_out = sync_in;
  end

  // Assertion qualifier: counts clocks since reset so that $past never reaches into reset.
  logic [1:0] warm_cnt;
  logic       warm;
  always_ff @(posedge clk_m or negedge rst_n) begin
    if (!rst_n)             warm_cnt <= 2'd0;
    else if (warm_cnt != 2'd3) warm_cnt <= warm_cnt + 2'd1;
  end
  assign warm = (warm_cnt == 2'd3);

  AST_RISE_FROM_INPUT: assert property (@(posedge clk_m) disable iff (!rst_n)
    (warm && edge_pol && edge_hit) |-> ($past(sync_in, 2) && !$past(sync_in, 3)))
    else $error("rising hit without rising input"); // R5
  AST_FALL_FROM_INPUT: assert property (@(posedge clk_m) disable iff (!rst_n)
    (warm && !edge_pol && edge_hit) |-> (!$past(sync_in, 2) && $past(sync_in, 3)))
    else $error("falling hit without falling input"); // R4
  AST_ZERO_DELAY: assert property (@(posedge clk_m) disable iff (!rst_n)
    (det_en && edge_hit && dly_sel == '0) |=> (!det_en || sync_out))
    else $error("zero-delay pulse missing"); // R10
  AST_ONE_DELAY: assert property (@(posedge clk_m) disable iff (!rst_n)
    (det_en && edge_hit && dly_sel == DLY_W'(1)) ##1 det_en |=> (!det_en || sync_out))
    else $error("one-clock delayed pulse missing"); // R3
endmodule

// File: tb/tb_sync_pulse_gen.sv
`timescale 1ns/1ps
module tb_sync_pulse_gen;
  logic       clk_m = 1'b0;
  logic       rst_n = 1'b0;
  logic       sync_in = 1'b0;
  logic       det_en = 1'b0;
  logic       edge_pol = 1'b0;
  logic [2:0] dly_sel = 3'd0;
  logic       sync_out;

  int    n_cmp = 0;
  int    n_bad = 0;
  string cur_req = "R8";
  bit    done = 1'b0;

  always #4 clk_m = ~clk_m;

  sync_pulse_gen dut (
    .clk_m(clk_m), .rst_n(rst_n), .sync_in(sync_in), .det_en(det_en),
    .edge_pol(edge_pol), .dly_sel(dly_sel), .sync_out(sync_out)
  );

  // Behavioural reference: last three sampled input levels and a list of fire times.
  int edge_no = 0;
  int hk1 = 0, hk2 = 0, hk3 = 0;
  int fire_q[$];
  bit exp_pulse;

  always @(posedge clk_m) begin
    bit qual;
    int sampled;
    edge_no++;
    sampled = (rst_n && sync_in) ? 1 : 0;
    qual = rst_n && det_en &&
           (edge_pol ? (hk2 == 1 && hk3 == 0) : (hk2 == 0 && hk3 == 1));
    if (!rst_n) begin
      hk1 = 0; hk2 = 0; hk3 = 0;
    end else begin
      hk3 = hk2; hk2 = hk1; hk1 = sampled;
    end
    if (!rst_n || !det_en) fire_q.delete();
    else if (qual) fire_q.push_back(edge_no + int'(dly_sel));
    exp_pulse = 1'b0;
    foreach (fire_q[i]) if (fire_q[i] == edge_no) exp_pulse = 1'b1;
    while (fire_q.size() > 0 && fire_q[0] <= edge_no) void'(fire_q.pop_front());
    #2;
    begin
      bit exp_out;
      exp_out = !rst_n ? 1'b0 : (det_en ? exp_pulse : sync_in);
      n_cmp++;
      if (sync_out !== exp_out) begin
        n_bad++;
        $display("FAIL %s cycle %0d: sync_out=%b expected=%b", cur_req, edge_no, sync_out, exp_out);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk_m);
  endtask

  task automatic pulse_in(input int hi, input int lo);
    sync_in = 1'b1; step(hi);
    sync_in = 1'b0; step(lo);
  endtask

  initial begin
    // R8: reset holds output low in both modes, even with input activity
    step(2);
    sync_in = 1'b1; step(2);
    det_en = 1'b1; sync_in = 1'b0; step(2);
    det_en = 1'b0; sync_in = 1'b0;
    step(1);
    rst_n = 1'b1;
    step(3);

    // R1: bypass follows input, settings irrelevant
    cur_req = "R1";
    for (int i = 0; i < 8; i++) begin
      edge_pol = i[0]; dly_sel = 3'(i);
      pulse_in(1 + i % 3, 2);
    end

    // R10: zero delay, rising
    cur_req = "R10";
    det_en = 1'b1; edge_pol = 1'b1; dly_sel = 3'd0;
    step(4);
    for (int i = 0; i < 3; i++) pulse_in(5, 5);

    // R3: each delay value, rising
    cur_req = "R3";
    for (int d = 1; d < 8; d++) begin
      dly_sel = 3'(d);
      pulse_in(6, 12);
    end

    // R4: falling polarity
    cur_req = "R4";
    edge_pol = 1'b0;
    for (int d = 0; d < 8; d += 3) begin
      dly_sel = 3'(d);
      pulse_in(6, 12);
    end

    // R5: rising polarity, falling ignored
    cur_req = "R5";
    edge_pol = 1'b1; dly_sel = 3'd2;
    pulse_in(9, 9);

    // R6: long high level gives one pulse only
    cur_req = "R6";
    dly_sel = 3'd4;
    pulse_in(30, 10);

    // R2: single-cycle input level is still captured
    cur_req = "R2";
    dly_sel = 3'd1;
    for (int i = 0; i < 3; i++) pulse_in(1, 6);

    // R7: overlapping pending pulses
    cur_req = "R7";
    dly_sel = 3'd7;
    for (int i = 0; i < 6; i++) pulse_in(2, 2);
    step(12);

    // R9: disable in the middle of a pending burst, then re-enable
    cur_req = "R9";
    for (int i = 0; i < 2; i++) pulse_in(2, 2);
    det_en = 1'b0; step(3);
    pulse_in(2, 2);
    det_en = 1'b1; step(12);
    pulse_in(2, 10);

    // R7: randomised mix of settings and edges
    cur_req = "R7";
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 9) == 0) det_en = ~det_en;
      if ($urandom_range(0, 19) == 0) edge_pol = ~edge_pol;
      if ($urandom_range(0, 7) == 0) dly_sel = 3'($urandom_range(0, 7));
      sync_in = 1'($urandom_range(0, 1));
      step(1);
    end

    // R8: reset asserted mid-activity
    cur_req = "R8";
    det_en = 1'b1; dly_sel = 3'd6; edge_pol = 1'b1;
    pulse_in(2, 2);
    rst_n = 1'b0; step(4);
    sync_in = 1'b0; rst_n = 1'b1; step(12);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_m);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog %s: run did not finish, expected completion", cur_req);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule